// File: doc/BRIEF.md
# Link-Side Bus Request Controller

This block sits in the link layer of a serial-bus node. It decides when the link asks the physical layer for the shared bus. Requesters hold level requests for four kinds of traffic: fair, priority, isochronous and acknowledge (take-bus). The block watches the 2-bit control code that the physical layer drives and picks one request at a time. It emits a one-cycle strobe carrying the request kind. A separate serialiser, outside this block, shifts that request onto the data lines.

A fair or priority request is lost if the physical layer starts receiving after the request has gone out. The block then re-issues the request once the interface has been idle for one full clock. An isochronous request needs a cycle-start first, and it survives incoming traffic. A take-bus request is placed while an addressed packet is still arriving, so the bus is granted the moment that packet ends. If the header CRC of that packet was bad, the grant is not used for anything. The block waits a fixed time and then signals that the bus is released.

Top module: `lreq_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, `req_stb_o`, `won_o` and `release_o` are 0 and `req_kind_o` is 0. After reset no request is outstanding and isochronous traffic is not armed.
- R2: Control codes are 00 idle, 10 receive, 11 grant (transmit may begin) and 01 status. A fair, priority or isochronous strobe is produced only at a clock edge where the control code is 00 and was also 00 at the previous edge.
- R3: A fair or priority request is lost when code 10 is sampled while it is outstanding. No request is then outstanding, and a later code 11 yields no `won_o`.
- R4: A lost request that is still held is strobed again on the second consecutive idle edge after the receive state ends.
- R5: An isochronous request is eligible from the edge after the one at which `cycle_start_i` is sampled high. It is no longer eligible from the edge after `iso_done_i` is sampled high.
- R6: An outstanding isochronous request is not lost by code 10. It stays outstanding until code 11 wins it or a take-bus request replaces it.
- R7: A take-bus strobe (kind 3) is produced at an edge where code 10 is present and `ack_req_i` is high, provided no take-bus or grant is in progress. This holds whether nothing is outstanding or a fair, priority or isochronous request is outstanding.
- R8: After a take-bus strobe, the end of the packet is the first edge that samples a code other than 10 after an edge that sampled 10. If `hdr_crc_ok_i` is high at that edge, `won_o` pulses in the following cycle.
- R9: If `hdr_crc_ok_i` is low at the end of the packet, neither `won_o` nor `req_stb_o` is raised until `release_o` pulses. That pulse comes exactly HOLD_CYC edges after the end edge. HOLD_CYC is the 160 ns wait rounded up to whole clocks (8 at a 20 ns clock).
- R10: When several requests are eligible, take-bus wins over isochronous, isochronous over priority, and priority over fair. The kind codes are 0 fair, 1 priority, 2 isochronous and 3 take-bus.
- R11: An outstanding fair, priority or isochronous request produces `won_o` in the cycle after code 11 is sampled. After a win, nothing is strobed until code 00 has been seen, and the R2 rule then applies again.
- R12: In any cycle at most one of `req_stb_o`, `won_o` and `release_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_i | input | 2 | Control code from the physical layer |
| fair_req_i | input | 1 | Fair request, held until won or dropped |
| prio_req_i | input | 1 | Priority request, held |
| iso_req_i | input | 1 | Isochronous request, held |
| cycle_start_i | input | 1 | Pulse: cycle-start message received |
| iso_done_i | input | 1 | Pulse: isochronous transfer finished |
| ack_req_i | input | 1 | Addressed packet arriving, acknowledge wanted |
| hdr_crc_ok_i | input | 1 | Header CRC of the arriving packet is valid |
| req_stb_o | output | 1 | One-cycle request strobe |
| req_kind_o | output | 2 | Kind of the latest request |
| won_o | output | 1 | One-cycle pulse: transmit may begin |
| release_o | output | 1 | One-cycle pulse: unused grant released |

## Verification
Some rules are checked by the embedded properties on every cycle. Fair, priority and isochronous strobes appear only after two idle samples, and take-bus strobes only during receive. Every win follows either a grant code or a packet end. Nothing is issued during the bad-CRC hold, and the strobe, win and release pulses never overlap. Other behaviour can only be shown by the bench's scenarios. These include the loss and retry sequence, the gating of isochronous requests by cycle-start and completion, and the priority order among simultaneous requests. They also include the exact edge on which the release pulse lands after a bad header.

// File: rtl/lreq_pkg.sv
// Shared types for the link request controller.
// Assumes: control codes as listed below; kinds are encoded in priority order.
package lreq_pkg;
    localparam logic [1:0] CTL_IDLE  = 2'b00;
    localparam logic [1:0] CTL_STAT  = 2'b01;
    localparam logic [1:0] CTL_RX    = 2'b10;
    localparam logic [1:0] CTL_GRANT = 2'b11;

    typedef enum logic [1:0] {
        K_FAIR = 2'd0,
        K_PRIO = 2'd1,
        K_ISO  = 2'd2,
        K_TAKE = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_FREE = 3'd0,
        ST_PEND = 3'd1,
        ST_TB   = 3'd2,
        ST_HOLD = 3'd3,
        ST_XMIT = 3'd4
    } req_state_e;
endpackage

// File: rtl/lreq_line_mon.sv
// Line monitor: decodes the control code and keeps one edge of history.
// Assumes: ctl_i is synchronous to clk; the status code is neither idle nor receive.
module lreq_line_mon
    import lreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_i,
    output logic       is_idle,
    output logic       is_rx,
    output logic       is_grant,
    output logic       idle_q,
    output logic       pkt_end
);
    logic rx_q;

    // Decode the present control code.
    always_comb begin
        is_idle  = (ctl_i == CTL_IDLE);
        is_rx    = (ctl_i == CTL_RX);
        is_grant = (ctl_i == CTL_GRANT);
        pkt_end  = rx_q && (ctl_i != CTL_RX);
    end

    // Remember whether the last edge saw idle or receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            idle_q <= is_idle;
            rx_q   <= is_rx;
        end
    end
endmodule

// File: rtl/lreq_pick.sv
// Request picker: arms isochronous traffic on cycle-start and selects the
// highest-ranked eligible non-acknowledge request (iso > prio > fair).
// Assumes: requests are levels held by their owners; done wins over start.
module lreq_pick
    import lreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fair_req_i,
    input  logic      prio_req_i,
    input  logic      iso_req_i,
    input  logic      cycle_start_i,
    input  logic      iso_done_i,
    output logic      pick_vld,
    output req_kind_e pick_kind
);
    logic iso_armed;

    // Track whether an isochronous request may be placed this cycle period.
    always_ff @(posedge clk) begin
        if (!rst_n)             iso_armed <= 1'b0;
        else if (iso_done_i)    iso_armed <= 1'b0;
        else if (cycle_start_i) iso_armed <= 1'b1;
    end

    // Fixed-priority selection among eligible requests.
    always_comb begin
        pick_vld  = 1'b1;
        pick_kind = K_FAIR;
        if (iso_armed && iso_req_i) pick_kind = K_ISO;
        else if (prio_req_i)        pick_kind = K_PRIO;
        else if (fair_req_i)        pick_kind = K_FAIR;
        else                        pick_vld  = 1'b0;
    end
endmodule

// File: rtl/lreq_hold_tmr.sv
// Hold timer: counts the forced wait after a bad-header grant.
// Assumes: HOLD_CYC >= 1; done is high on the last counted cycle.
module lreq_hold_tmr #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC);

    logic [CW-1:0] cnt;

    // Load on request, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Flag the final cycle of the wait.
    always_comb done = (cnt == CW'(1));

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_VAL); // R9
endmodule

// File: rtl/lreq_ctrl.sv
// Link request controller top: one outstanding request at a time, loss on
// receive with retry after idle, take-bus during reception, and a timed
// release of an unused grant after a bad header CRC.
// Assumes: the wait is HOLD_NS rounded up to clocks of CLK_NS.
module lreq_ctrl
    import lreq_pkg::*;
#(
    parameter int CLK_NS  = 20,
    parameter int HOLD_NS = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_i,
    input  logic       fair_req_i,
    input  logic       prio_req_i,
    input  logic       iso_req_i,
    input  logic       cycle_start_i,
    input  logic       iso_done_i,
    input  logic       ack_req_i,
    input  logic       hdr_crc_ok_i,
    output logic       req_stb_o,
    output logic [1:0] req_kind_o,
    output logic       won_o,
    output logic       release_o
);
    localparam int HOLD_CYC = (HOLD_NS + CLK_NS - 1) / CLK_NS;

    logic       is_idle, is_rx, is_grant, idle_q, pkt_end;
    logic       pick_vld, tmr_load, tmr_done;
    req_kind_e  pick_kind, kind_q, kind_n;
    req_state_e st, st_n;
    logic       stb_n, won_n, rel_n;

    lreq_line_mon u_mon (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i),
        .is_idle(is_idle), .is_rx(is_rx), .is_grant(is_grant),
        .idle_q(idle_q), .pkt_end(pkt_end)
    );

    lreq_pick u_pick (
        .clk(clk), .rst_n(rst_n),
        .fair_req_i(fair_req_i), .prio_req_i(prio_req_i), .iso_req_i(iso_req_i),
        .cycle_start_i(cycle_start_i), .iso_done_i(iso_done_i),
        .pick_vld(pick_vld), .pick_kind(pick_kind)
    );

    lreq_hold_tmr #(.HOLD_CYC(HOLD_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done)
    );

    // Next state and next output pulses.
    always_comb begin
        st_n     = st;
        kind_n   = kind_q;
        stb_n    = 1'b0;
        won_n    = 1'b0;
        rel_n    = 1'b0;
        tmr_load = 1'b0;
        case (st)
            ST_FREE: begin
                if (is_rx && ack_req_i) begin
                    stb_n = 1'b1; kind_n = K_TAKE; st_n = ST_TB;
                end else if (is_idle && idle_q && pick_vld) begin
                    stb_n = 1'b1; kind_n = pick_kind; st_n = ST_PEND;
                end
            end
            ST_PEND: begin
                if (is_rx && ack_req_i) begin
                    stb_n = 1'b1; kind_n = K_TAKE; st_n = ST_TB;
                end else if (is_grant) begin
                    won_n = 1'b1; st_n = ST_XMIT;
                end else if (is_rx && kind_q != K_ISO) begin
                    st_n = ST_FREE;
                end
            end
            ST_TB: begin
                if (pkt_end) begin
                    if (hdr_crc_ok_i) begin
                        won_n = 1'b1; st_n = ST_XMIT;
                    end else begin
                        tmr_load = 1'b1; st_n = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    rel_n = 1'b1; st_n = ST_FREE;
                end
            end
            ST_XMIT: begin
                if (is_idle) st_n = ST_FREE;
            end
            default: st_n = ST_FREE;
        endcase
    end

    // Register state, kind and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_FREE;
            kind_q    <= K_FAIR;
            req_stb_o <= 1'b0;
            won_o     <= 1'b0;
            release_o <= 1'b0;
        end else begin
            st        <= st_n;
            kind_q    <= kind_n;
            req_stb_o <= stb_n;
            won_o     <= won_n;
            release_o <= rel_n;
        end
    end

    // Drive the kind output from the registered kind.
    always_comb req_kind_o = kind_q;

    AST_FP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb_o && req_kind_o != K_TAKE) |-> ($past(ctl_i) == CTL_IDLE && $past(ctl_i, 2) == CTL_IDLE)); // R2
    AST_TB_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb_o && req_kind_o == K_TAKE) |-> ($past(ctl_i) == CTL_RX)); // R7
    AST_WON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |-> ($past(ctl_i) == CTL_GRANT || ($past(ctl_i, 2) == CTL_RX && $past(ctl_i) != CTL_RX))); // R8
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> (!won_o && !req_stb_o)); // R9
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_stb_o, won_o, release_o})); // R12
endmodule

// File: tb/lreq_ctrl_test.sv
module lreq_ctrl_test;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ctl;
    logic fair, prio, iso, cstart, idone, ack, crc;
    logic       stb, won, rel;
    logic [1:0] kind;
    int total = 0, bad = 0;
    logic [1:0] hc = 2'b00, hp = 2'b00;

    always #10 clk = ~clk;

    lreq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl),
        .fair_req_i(fair), .prio_req_i(prio), .iso_req_i(iso),
        .cycle_start_i(cstart), .iso_done_i(idone),
        .ack_req_i(ack), .hdr_crc_ok_i(crc),
        .req_stb_o(stb), .req_kind_o(kind), .won_o(won), .release_o(rel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge; hc/hp hold the codes sampled at this and the previous edge.
    task automatic step();
        logic [1:0] cur;
        cur = ctl;
        @(posedge clk);
        #2;
        hp = hc;
        hc = cur;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ctl = 2'b00;
        fair = 0; prio = 0; iso = 0; cstart = 0; idone = 0; ack = 0; crc = 1;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Expected kind for a non-acknowledge strobe, from R10.
    function automatic int exp_kind(input bit f, input bit p, input bit i_ok);
        if (i_ok) return 2;
        if (p) return 1;
        if (f) return 0;
        return -1;
    endfunction

    function automatic bit fp_legal(input logic [1:0] now, input logic [1:0] prev);
        return (now == 2'b00) && (prev == 2'b00);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset state
        do_reset();
        chk(!stb && !won && !rel && kind == 0, "R1", {stb, won, rel}, 0);
        step();
        chk(!stb && !won && !rel, "R1", {stb, won, rel}, 0);

        // R2 first strobe needs two idle edges; R3 loss; R4 retry
        do_reset();
        fair = 1;
        step(); chk(!stb, "R2", stb, 0);
        step(); chk(stb && kind == 0, "R2", {stb, kind}, 4);
        ctl = 2'b10; step(); chk(!stb, "R3", stb, 0);
        ctl = 2'b11; step(); chk(!won, "R3", won, 0);
        ctl = 2'b00; step(); chk(!stb, "R4", stb, 0);
        step(); chk(stb && kind == 0, "R4", {stb, kind}, 4);
        ctl = 2'b11; step(); chk(won, "R11", won, 1);
        fair = 0; step(); chk(!stb && !won, "R11", {stb, won}, 0);
        ctl = 2'b00; step(); step();
        chk(!stb, "R11", stb, 0);

        // R5 isochronous gating, R6 survives receive
        do_reset();
        iso = 1;
        step(); step(); step(); chk(!stb, "R5", stb, 0);
        cstart = 1; step(); cstart = 0;
        step(); chk(stb && kind == exp_kind(0, 0, 1), "R5", kind, 2);
        ctl = 2'b10; step(); step(); step(); chk(!stb && !won, "R6", {stb, won}, 0);
        ctl = 2'b11; step(); chk(won, "R6", won, 1);
        ctl = 2'b00; idone = 1; step(); idone = 0;
        step(); step(); step(); chk(!stb, "R5", stb, 0);

        // R10 ordering, R7 take-bus preempts, R8 good CRC
        do_reset();
        fair = 1; prio = 1; iso = 1; cstart = 1; step(); cstart = 0;
        step(); chk(stb && kind == exp_kind(1, 1, 1), "R10", kind, 2);
        ctl = 2'b10; ack = 1; step(); chk(stb && kind == 3, "R7", kind, 3);
        ack = 0; step(); chk(!stb && !won, "R7", {stb, won}, 0);
        ctl = 2'b00; crc = 1; step(); chk(won && !stb, "R8", won, 1);
        iso = 0; step(); chk(!won, "R8", won, 0);
        step(); chk(stb && kind == exp_kind(1, 1, 0), "R10", kind, 1);
        ctl = 2'b10; prio = 0; step();
        ctl = 2'b00; step(); step(); chk(stb && kind == 0, "R10", kind, 0);

        // R9 bad CRC: silent hold, release exactly HOLD edges after end
        do_reset();
        fair = 1; ctl = 2'b10; ack = 1;
        step(); chk(stb && kind == 3, "R7", kind, 3);
        ack = 0; ctl = 2'b00; crc = 0;
        step(); chk(!won && !rel && !stb, "R9", {stb, won, rel}, 0);
        for (int k = 1; k < HOLD; k++) begin
            step(); chk(!won && !rel && !stb, "R9", {stb, won, rel}, 0);
        end
        step(); chk(rel && !won && !stb, "R9", rel, 1);
        step(); chk(stb && kind == 0, "R9", {stb, kind}, 4);
        crc = 1; fair = 0;

        // Random traffic with invariants
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            ctl = (r < 5) ? 2'b00 : (r < 7) ? 2'b10 : (r < 9) ? 2'b11 : 2'b01;
            fair = $urandom_range(0, 1);
            prio = ($urandom_range(0, 3) == 0);
            iso = $urandom_range(0, 1);
            cstart = ($urandom_range(0, 15) == 0);
            idone = ($urandom_range(0, 15) == 0);
            ack = ($urandom_range(0, 3) == 0);
            crc = ($urandom_range(0, 3) != 0);
            step();
            chk(32'(stb) + 32'(won) + 32'(rel) <= 1, "R12", stb + won + rel, 1);
            if (stb && kind != 3) chk(fp_legal(hc, hp), "R2", hc, 0);
            if (stb && kind == 3) chk(hc == 2'b10, "R7", hc, 2);
            if (won) chk(hc == 2'b11 || (hp == 2'b10 && hc != 2'b10), "R8", hc, 3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule